// File: doc/BRIEF.md
# EEPROM Status Register and Write-Protection Guard

This block keeps the status register of a serial EEPROM and decides whether a write to the memory array or to the status register may proceed. The register holds a write-enable latch, a two-bit block-protect level, a hardware-lock enable bit, and a busy indication that comes from the programming timer. The command decoder drives set and clear requests for the write-enable latch. It presents the status-write data while chip select is low and supplies the address of any array write. The guard returns the status byte for reads, a flag that says whether the candidate address lies in a protected block, and a flag that says whether a status write may be accepted.

A status write is staged while chip select is low and committed on the rising edge of chip select. If the hardware lock becomes active before that edge, the staged write is dropped. Once the write has been committed, later changes on the write-protect pin have no effect on it. The serial shifter and the programming timer are outside the block. The timer is seen only through its busy level and a one-cycle done pulse.

Top module: `eeprom_status_guard`

## Requirements
- R1: After reset, status_byte is 8'h00, sr_write_ok is 0, and addr_protected is 0 for every address.
- R2: While busy is 0, status_byte is {lock enable, 3'b000, block level[1:0], write-enable latch, 1'b0}, with the lock enable in bit 7, the level in bits 3:2 and the latch in bit 1. While busy is 1, status_byte reads 8'hFF.
- R3: A wen_set pulse sets the write-enable latch at the next clock edge. A wen_clr pulse clears it whatever the level of wp_level, and wen_clr wins when both arrive together. Both requests are ignored while busy is 1. A done pulse always clears the latch.
- R4: addr_protected is combinational. Level 00 protects no address. Level 01 protects the addresses whose two top bits are 11. Level 10 protects those whose top bit is 1. Level 11 protects every address.
- R5: sr_write_ok is 1 exactly when the latch is 1, busy is 0 and the hardware lock is off. The hardware lock is on when the lock enable is 1 and wp_level is 0.
- R6: A sr_load pulse while cs_n is 0 and sr_write_ok is 1 stages bits 7, 3 and 2 of sr_wr_data. They appear in status_byte from the clock edge at which cs_n is first seen high, and not before.
- R7: A sr_load pulse while sr_write_ok is 0, or while cs_n is 1, leaves the lock enable and the block level unchanged.
- R8: If the hardware lock becomes active at a clock edge while a staged write waits for cs_n to rise, the staged write is discarded. A write that has already been committed is unaffected by a later change of wp_level.
- R9: While wp_level is 0 and the lock enable is 1, the lock enable cannot be returned to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select level, active low |
| wp_level | input | 1 | Write-protect pin level, 0 means protect |
| busy | input | 1 | Internal programming cycle in progress |
| done | input | 1 | One-cycle pulse at the end of a programming cycle |
| wen_set | input | 1 | Request to set the write-enable latch |
| wen_clr | input | 1 | Request to clear the write-enable latch |
| sr_load | input | 1 | Status-write data valid |
| sr_wr_data | input | 8 | Status-write data byte |
| cand_addr | input | ADDR_W | Address of a pending array write |
| status_byte | output | 8 | Status register as returned by a status read |
| addr_protected | output | 1 | cand_addr lies in a protected block |
| sr_write_ok | output | 1 | A status write may be accepted now |

## Verification
The bench goes after the staged-write window. In one case WP falls while chip select is still low, and a design that ignores the cancel would commit a lock it should have refused. In another case WP falls after the commit, and a design that cancels too late would lose a write that had already begun. It also tries to clear the lock enable with WP held low, which would unlock the register if the lock were checked only at load time. It checks the clear request under a low WP and the busy all-ones read. Finally it sweeps addresses around the quarter and half boundaries, where an off-by-one in the decoded top bits would protect the wrong block.

// File: rtl/eeprom_sr_pkg.sv
package eeprom_sr_pkg;
   typedef enum logic [1:0] {
      BP_NONE    = 2'b00,
      BP_QUARTER = 2'b01,
      BP_HALF    = 2'b10,
      BP_ALL     = 2'b11
   } bp_level_e;

   typedef struct packed {
      logic      lock_en;
      bp_level_e level;
   } sr_nv_t;

   localparam int unsigned SR_W     = 8;
   localparam int unsigned POS_LOCK = 7;
   localparam int unsigned POS_BP_H = 3;
   localparam int unsigned POS_BP_L = 2;
   localparam int unsigned POS_WEL  = 1;
   localparam int unsigned POS_BUSY = 0;
endpackage

// File: rtl/sr_prot_decode.sv
module sr_prot_decode
   import eeprom_sr_pkg::*;
#(
   parameter int unsigned ADDR_W = 11
) (
   input  bp_level_e           level,
   input  logic [ADDR_W-1:0]   addr,
   output logic                prot
);
   localparam int unsigned TOP = ADDR_W - 1;

   logic [1:0] hi;
   logic       unused_low;

   assign hi         = addr[TOP -: 2];
   assign unused_low = ^addr[ADDR_W-3:0];

   always_comb begin
      case (level)
         BP_NONE:    prot = 1'b0;
         BP_QUARTER: prot = &hi;
         BP_HALF:    prot = hi[1];
         default:    prot = 1'b1;
      endcase
   end
endmodule

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic done,
   input  logic set_req,
   input  logic clr_req,
   output logic wel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
      end else if (done) begin
         wel <= 1'b0;
      end else if (!busy && clr_req) begin
         wel <= 1'b0;
      end else if (!busy && set_req) begin
         wel <= 1'b1;
      end
   end
endmodule

// File: rtl/sr_nv_store.sv
module sr_nv_store
   import eeprom_sr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   cs_n,
   input  logic   hw_lock,
   input  logic   load_ok,
   input  sr_nv_t wr_nv,
   output sr_nv_t nv_q
);
   logic   cs_prev;
   logic   pend;
   sr_nv_t pend_nv;
   logic   cs_rise;

   assign cs_rise = cs_n && !cs_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev <= 1'b1;
         pend    <= 1'b0;
         pend_nv <= '0;
         nv_q    <= '0;
      end else begin
         cs_prev <= cs_n;
         if (hw_lock) begin
            pend <= 1'b0;
         end else if (cs_rise) begin
            pend <= 1'b0;
            if (pend) nv_q <= pend_nv;
         end else if (load_ok) begin
            pend    <= 1'b1;
            pend_nv <= wr_nv;
         end
      end
   end
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
   import eeprom_sr_pkg::*;
#(
   parameter int unsigned ADDR_W        = 11,
   parameter bit          BUSY_ALL_ONES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wp_level,
   input  logic              busy,
   input  logic              done,
   input  logic              wen_set,
   input  logic              wen_clr,
   input  logic              sr_load,
   input  logic [SR_W-1:0]   sr_wr_data,
   input  logic [ADDR_W-1:0] cand_addr,
   output logic [SR_W-1:0]   status_byte,
   output logic              addr_protected,
   output logic              sr_write_ok
);
   if (ADDR_W < 3) begin : g_bad_width
      $error("eeprom_status_guard: ADDR_W must be at least 3");
   end

   logic   wel_q;
   logic   wpen_q;
   logic   hw_lock;
   logic   load_ok;
   sr_nv_t wr_nv;
   sr_nv_t nv_q;
   logic   unused_data;

   assign wr_nv.lock_en = sr_wr_data[POS_LOCK];
   assign wr_nv.level   = bp_level_e'(sr_wr_data[POS_BP_H:POS_BP_L]);
   assign unused_data   = ^{sr_wr_data[6:4], sr_wr_data[POS_WEL], sr_wr_data[POS_BUSY]};

   assign wpen_q      = nv_q.lock_en;
   assign hw_lock     = wpen_q && !wp_level;
   assign sr_write_ok = wel_q && !busy && !hw_lock;
   assign load_ok     = sr_load && !cs_n && sr_write_ok;

   sr_wel_latch i_wel (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .done    (done),
      .set_req (wen_set),
      .clr_req (wen_clr),
      .wel     (wel_q)
   );

   sr_nv_store i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .hw_lock (hw_lock),
      .load_ok (load_ok),
      .wr_nv   (wr_nv),
      .nv_q    (nv_q)
   );

   sr_prot_decode #(.ADDR_W(ADDR_W)) i_dec (
      .level (nv_q.level),
      .addr  (cand_addr),
      .prot  (addr_protected)
   );

   logic [SR_W-1:0] idle_byte;
   assign idle_byte = {wpen_q, 3'b000, nv_q.level, wel_q, 1'b0};

   if (BUSY_ALL_ONES) begin : g_busy_ones
      assign status_byte = busy ? {SR_W{1'b1}} : idle_byte;
   end else begin : g_busy_bit
      assign status_byte = {idle_byte[SR_W-1:1], busy};
   end
endmodule

// File: rtl/eeprom_status_guard_chk.sv
module eeprom_status_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wp_level,
   input logic       busy,
   input logic       done,
   input logic [7:0] status_byte,
   input logic       addr_protected,
   input logic       sr_write_ok,
   input logic       wel,
   input logic       wpen
);
   assert_busy_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> status_byte[0]);

   assert_idle_zeros_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (status_byte[6:4] == 3'b000) && !status_byte[0]);

   assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !wel);

   assert_full_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && status_byte[3:2] == 2'b11) |-> addr_protected);

   assert_lock_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wpen && !wp_level) |-> !sr_write_ok);

   assert_no_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wel |-> !sr_write_ok);

   assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wpen && !wp_level) |=> wpen);
endmodule

bind eeprom_status_guard eeprom_status_guard_chk i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wp_level       (wp_level),
   .busy           (busy),
   .done           (done),
   .status_byte    (status_byte),
   .addr_protected (addr_protected),
   .sr_write_ok    (sr_write_ok),
   .wel            (wel_q),
   .wpen           (wpen_q)
);

// File: tb/test_eeprom_status_guard.sv
`timescale 1ns/1ps
module test_eeprom_status_guard;
   localparam int unsigned AW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, wp_level = 1'b1, busy = 1'b0, done = 1'b0;
   logic          wen_set = 1'b0, wen_clr = 1'b0, sr_load = 1'b0;
   logic [7:0]    sr_wr_data = 8'h00;
   logic [AW-1:0] cand_addr = '0;
   logic [7:0]    status_byte;
   logic          addr_protected, sr_write_ok;

   int total = 0, bad = 0;
   bit finished = 1'b0;
   string tag = "R2";

   logic       m_wel = 1'b0, m_wpen = 1'b0, m_pend = 1'b0, m_csp = 1'b1;
   logic [1:0] m_bp = 2'b00;
   logic [7:0] m_pdata = 8'h00;

   always #5 clk = ~clk;

   eeprom_status_guard #(.ADDR_W(AW)) i_eeprom_status_guard (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_level(wp_level), .busy(busy),
      .done(done), .wen_set(wen_set), .wen_clr(wen_clr), .sr_load(sr_load),
      .sr_wr_data(sr_wr_data), .cand_addr(cand_addr), .status_byte(status_byte),
      .addr_protected(addr_protected), .sr_write_ok(sr_write_ok)
   );

   function automatic logic exp_prot(input logic [1:0] bp, input logic [AW-1:0] a);
      case (bp)
         2'b00:   return 1'b0;
         2'b01:   return a[AW-1] & a[AW-2];
         2'b10:   return a[AW-1];
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [7:0] exp_status();
      return busy ? 8'hFF : {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
   endfunction

   function automatic logic exp_ok();
      return m_wel & ~busy & ~(m_wpen & ~wp_level);
   endfunction

   task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
      end
   endtask

   task automatic model_step();
      logic hw, ok, rise;
      hw   = m_wpen & ~wp_level;
      ok   = m_wel & ~busy & ~hw;
      rise = cs_n & ~m_csp;
      if (done) m_wel = 1'b0;
      else if (!busy && wen_clr) m_wel = 1'b0;
      else if (!busy && wen_set) m_wel = 1'b1;
      if (hw) m_pend = 1'b0;
      else if (rise) begin
         if (m_pend) begin
            m_wpen = m_pdata[7];
            m_bp   = m_pdata[3:2];
         end
         m_pend = 1'b0;
      end else if (!cs_n && sr_load && ok) begin
         m_pend  = 1'b1;
         m_pdata = sr_wr_data;
      end
      m_csp = cs_n;
   endtask

   task automatic tick();
      #1;
      chk(status_byte == exp_status(), {tag, " status"}, status_byte, exp_status());
      chk(addr_protected == exp_prot(m_bp, cand_addr), "R4 protect", addr_protected, exp_prot(m_bp, cand_addr));
      chk(sr_write_ok == exp_ok(), "R5 write_ok", sr_write_ok, exp_ok());
      @(posedge clk);
      model_step();
      @(negedge clk);
      wen_set = 1'b0; wen_clr = 1'b0; sr_load = 1'b0; done = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      #1;
      chk(status_byte == 8'h00, "R1 status", status_byte, 8'h00);
      chk(sr_write_ok == 1'b0, "R1 write_ok", sr_write_ok, 0);
      cand_addr = '1;
      #1;
      chk(addr_protected == 1'b0, "R1 protect", addr_protected, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 latch control
      tag = "R3";
      wen_set = 1'b1; tick();
      chk(status_byte == 8'h02, "R3 set", status_byte, 8'h02);
      busy = 1'b1; wen_clr = 1'b1; tick();
      busy = 1'b0; #1;
      chk(status_byte[1] == 1'b1, "R3 clr ignored busy", status_byte[1], 1);
      wp_level = 1'b0; wen_clr = 1'b1; tick();
      chk(status_byte == 8'h00, "R3 clr with WP low", status_byte, 8'h00);
      wp_level = 1'b1; wen_set = 1'b1; wen_clr = 1'b1; tick();
      chk(status_byte == 8'h00, "R3 clr wins", status_byte, 8'h00);
      wen_set = 1'b1; tick(); done = 1'b1; tick();
      chk(status_byte == 8'h00, "R3 done clears", status_byte, 8'h00);

      // R6 staged commit at CS rise
      tag = "R6";
      wen_set = 1'b1; tick();
      cs_n = 1'b0; sr_load = 1'b1; sr_wr_data = 8'h8C; tick();
      tick();
      chk(status_byte == 8'h02, "R6 not before rise", status_byte, 8'h02);
      cs_n = 1'b1; tick();
      chk(status_byte == 8'h8E, "R6 commit", status_byte, 8'h8E);
      cand_addr = '0; #1;
      chk(addr_protected == 1'b1, "R4 all level", addr_protected, 1);

      // R9 lock enable sticky under WP low
      tag = "R9";
      wp_level = 1'b0; #1;
      chk(sr_write_ok == 1'b0, "R5 lock", sr_write_ok, 0);
      cs_n = 1'b0; sr_load = 1'b1; sr_wr_data = 8'h00; tick();
      cs_n = 1'b1; tick();
      chk(status_byte == 8'h8E, "R9 lock held", status_byte, 8'h8E);

      // R8 cancel before rise
      tag = "R8";
      wp_level = 1'b1; cs_n = 1'b0; sr_load = 1'b1; sr_wr_data = 8'h84; tick();
      wp_level = 1'b0; tick();
      wp_level = 1'b1; cs_n = 1'b1; tick();
      chk(status_byte == 8'h8E, "R8 cancelled", status_byte, 8'h8E);
      cs_n = 1'b0; sr_load = 1'b1; sr_wr_data = 8'h04; tick();
      cs_n = 1'b1; tick();
      wp_level = 1'b0; tick();
      chk(status_byte == 8'h06, "R8 committed kept", status_byte, 8'h06);

      // R4 quarter boundary
      cand_addr = {2'b11, {(AW-2){1'b0}}}; #1;
      chk(addr_protected == 1'b1, "R4 quarter in", addr_protected, 1);
      cand_addr = {2'b10, {(AW-2){1'b1}}}; #1;
      chk(addr_protected == 1'b0, "R4 quarter out", addr_protected, 0);

      // R7 refused loads
      tag = "R7";
      wp_level = 1'b1; wen_clr = 1'b1; tick();
      cs_n = 1'b0; sr_load = 1'b1; sr_wr_data = 8'h8C; tick();
      cs_n = 1'b1; tick();
      chk(status_byte == 8'h04, "R7 no wel", status_byte, 8'h04);
      wen_set = 1'b1; tick();
      sr_load = 1'b1; sr_wr_data = 8'h88; tick(); tick();
      chk(status_byte == 8'h06, "R7 cs high load", status_byte, 8'h06);

      busy = 1'b1; #1;
      chk(status_byte == 8'hFF, "R2 busy ones", status_byte, 8'hFF);
      busy = 1'b0;

      // random phase
      for (int i = 0; i < 4000; i++) begin
         tag        = "R2";
         busy       = ($urandom % 5) == 0;
         done       = ($urandom % 20) == 0;
         wp_level   = ($urandom % 10) < 7;
         if (($urandom % 10) < 3) cs_n = ~cs_n;
         wen_set    = ($urandom % 6) == 0;
         wen_clr    = ($urandom % 10) == 0;
         sr_load    = ($urandom % 3) == 0;
         sr_wr_data = 8'($urandom);
         cand_addr  = AW'($urandom);
         tick();
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule